// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM from power-up into working order with no processor involved. A one-cycle start pulse enables the clock-enable line. The block then steps through a fixed list of mode-programming commands on a single-phase command port, and separates the commands with wait intervals whose lengths are set by parameters. The port has four active-low strobes, a 13-bit row address and a 2-bit bank address. When the list is finished the block raises `done` and holds it.

The sequence runs in this order:
1. Clock-enable settle.
2. Precharge-all.
3. Extended-mode load.
4. Mode load with DLL reset, then a long DLL wait.
5. A second precharge-all.
6. Two auto-refreshes, each followed by a short wait.
7. A final mode load without DLL reset, then a long wait.

Each row address is stored as a high field (row bits 12:5) and a low field (row bits 4:0). The block joins the two fields again before driving the address port.

Top module: `ddr_powerup_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `cke` is 0, all four strobes are 1, `busy` and `done` are 0, and `addr` and `ba` are 0. Reset is synchronous and active high.
- R2: A `start` sampled high while the block is idle makes `busy` and `cke` go to 1 in the next cycle. In that cycle all strobes are 1, `addr` is 0 and `ba` is 0 (the clock-enable settle step).
- R3: In any cycle where no command is issued, the strobes `cs_n`, `ras_n`, `cas_n` and `we_n` are all 1 (NOP).
- R4: The commands come in this order, with strobes given as {cs_n,ras_n,cas_n,we_n}:
  - precharge-all, 0010, addr 0x0400, ba 0;
  - extended-mode load, 0000, addr 0x0000, ba 1;
  - mode load, 0000, addr 0x0132, ba 0;
  - precharge-all, 0010, addr 0x0400;
  - exactly two auto-refreshes, 0001, addr 0x0000;
  - mode load, 0000, addr 0x0032, ba 0.
  That makes seven commands in total.
- R5: Each command lasts exactly one cycle. `addr` and `ba` keep the values of the latest step until the next step starts.
- R6: Each step is followed by a number of NOP cycles, after which the next step (or `done`) follows at once:
  - `T_CKE` after the clock-enable step;
  - `T_GAP` after each precharge and after the extended-mode load;
  - `T_DLL` after the DLL-reset mode load;
  - `T_RFC` after each refresh;
  - `T_MODE` after the final mode load.
- R7: The driven row address joins the high field into bits 12:5 and the low field into bits 4:0. For example, 0x0132 has high field 0x09 and low field 0x12.
- R8: A `start` pulse that arrives while `busy` is 1 is ignored. The sequence and its length are unchanged.
- R9: `done` stays 1 until the next `start`. A `start` sampled while `done` is 1 restarts the sequence: in the next cycle `busy` is 1, `done` is 0 and `cke` stays 1.
- R10: `busy` and `done` are never both 1. `busy` falls in the same cycle that `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; held until next start |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 13 | Row address for the current step |
| ba | output | 2 | Bank address for the current step |

## Verification
The bench runs the sequence with shortened waits, so a wait counter that is off by one cycle moves every later command. This shows up as a mismatch on the first cycle after the faulty interval.

It pulses `start` several times in the middle of a run. A design that re-armed on such a pulse would restart at the clock-enable step and run longer than expected.

It also restarts from the finished state and cuts a run short with reset. A design that cleared `done` on its own, let `cke` drop on a restart, or kept `cke` high after reset would fail at once.

Finally, the bench counts the refreshes and checks addresses whose high and low fields are both non-zero. This catches a swapped field join, a third refresh, or a refresh encoded with `we_n` low.

// File: rtl/ddr_powerup_pkg.sv
package ddr_powerup_pkg;

    localparam int ROW_W     = 13;
    localparam int BANK_W    = 2;
    localparam int LO_W      = 5;
    localparam int HI_W      = ROW_W - LO_W;
    localparam int NUM_STEPS = 8;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef enum logic [1:0] {OP_NOP, OP_PRE, OP_REF, OP_MRS} op_e;
    typedef enum logic [2:0] {W_CKE, W_GAP, W_DLL, W_RFC, W_MODE} wsel_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    typedef struct packed {
        op_e               op;
        logic [BANK_W-1:0] bank;
        logic [HI_W-1:0]   row_hi;
        logic [LO_W-1:0]   row_lo;
        wsel_e             wsel;
    } step_t;

    localparam strobe_t STB_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic strobe_t encode_op(op_e op);
        strobe_t s;
        s = STB_IDLE;
        case (op)
            OP_PRE: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            OP_REF: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            OP_MRS: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default: s = STB_IDLE;
        endcase
        return s;
    endfunction

    function automatic logic [ROW_W-1:0] join_row(logic [HI_W-1:0] hi, logic [LO_W-1:0] lo);
        return {hi, lo};
    endfunction

    // Fixed program: settle, precharge, ext-mode, mode+DLL reset,
    // precharge, refresh x2, mode without DLL reset.
    function automatic step_t step_at(logic [STEP_W-1:0] idx);
        step_t s;
        case (idx)
            3'd0:    s = '{op: OP_NOP, bank: 2'd0, row_hi: 8'h00, row_lo: 5'h00, wsel: W_CKE};
            3'd1:    s = '{op: OP_PRE, bank: 2'd0, row_hi: 8'h20, row_lo: 5'h00, wsel: W_GAP};
            3'd2:    s = '{op: OP_MRS, bank: 2'd1, row_hi: 8'h00, row_lo: 5'h00, wsel: W_GAP};
            3'd3:    s = '{op: OP_MRS, bank: 2'd0, row_hi: 8'h09, row_lo: 5'h12, wsel: W_DLL};
            3'd4:    s = '{op: OP_PRE, bank: 2'd0, row_hi: 8'h20, row_lo: 5'h00, wsel: W_GAP};
            3'd5:    s = '{op: OP_REF, bank: 2'd0, row_hi: 8'h00, row_lo: 5'h00, wsel: W_RFC};
            3'd6:    s = '{op: OP_REF, bank: 2'd0, row_hi: 8'h00, row_lo: 5'h00, wsel: W_RFC};
            default: s = '{op: OP_MRS, bank: 2'd0, row_hi: 8'h01, row_lo: 5'h12, wsel: W_MODE};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));

    // R6: a loaded wait interval counts down one per cycle
    a_r6_countdown: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

endmodule

// File: rtl/seq_cmd_drive.sv
module seq_cmd_drive
    import ddr_powerup_pkg::*;
(
    input  logic              issue,
    input  step_t             step,
    output strobe_t           strobes,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank
);

    always_comb begin
        strobes = issue ? encode_op(step.op) : STB_IDLE;
        row     = join_row(step.row_hi, step.row_lo);
        bank    = step.bank;
    end

endmodule

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq
    import ddr_powerup_pkg::*;
#(
    parameter int T_CKE  = 4,
    parameter int T_GAP  = 2,
    parameter int T_DLL  = 200,
    parameter int T_RFC  = 4,
    parameter int T_MODE = 200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic        cke,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [12:0] addr,
    output logic [1:0]  ba
);

    localparam int T_MAX_A = (T_CKE > T_GAP) ? T_CKE : T_GAP;
    localparam int T_MAX_B = (T_DLL > T_RFC) ? T_DLL : T_RFC;
    localparam int T_MAX_C = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int T_MAX   = (T_MAX_C > T_MODE) ? T_MAX_C : T_MODE;
    localparam int CNT_W   = $clog2(T_MAX + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef enum logic [1:0] {S_IDLE, S_CMD, S_WAIT, S_DONE} state_e;

    state_e            state;
    logic [STEP_W-1:0] step_idx;
    step_t             cur_step;
    strobe_t           stb;
    logic [CNT_W-1:0]  wait_len;
    logic              wait_last;

    function automatic logic [CNT_W-1:0] wait_for(wsel_e w);
        case (w)
            W_CKE:   return CNT_W'(T_CKE);
            W_GAP:   return CNT_W'(T_GAP);
            W_DLL:   return CNT_W'(T_DLL);
            W_RFC:   return CNT_W'(T_RFC);
            default: return CNT_W'(T_MODE);
        endcase
    endfunction

    assign cur_step = step_at(step_idx);
    assign wait_len = wait_for(cur_step.wsel);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            step_idx <= '0;
        end else begin
            case (state)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        step_idx <= '0;
                        state    <= S_CMD;
                    end
                end
                S_CMD: state <= S_WAIT;
                S_WAIT: begin
                    if (wait_last) begin
                        if (step_idx == LAST_STEP) begin
                            state <= S_DONE;
                        end else begin
                            step_idx <= step_idx + 1'b1;
                            state    <= S_CMD;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (state == S_CMD),
        .load_val (wait_len),
        .last     (wait_last)
    );

    seq_cmd_drive u_drive (
        .issue   (state == S_CMD),
        .step    (cur_step),
        .strobes (stb),
        .row     (addr),
        .bank    (ba)
    );

    assign cs_n  = stb.cs_n;
    assign ras_n = stb.ras_n;
    assign cas_n = stb.cas_n;
    assign we_n  = stb.we_n;
    assign busy  = (state == S_CMD) || (state == S_WAIT);
    assign done  = (state == S_DONE);
    assign cke   = (state != S_IDLE);

    // R1: idle after reset keeps clock enable low and strobes at NOP
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |-> (!cke && cs_n && ras_n && cas_n && we_n));

    // R2: busy only rises after an accepted start
    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R5: a command occupies a single cycle
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> cs_n);

    // R8: start during a run does not rewind the step pointer
    a_r8_no_rewind: assert property (@(posedge clk) disable iff (rst)
        (busy && start && step_idx != '0) |=> (step_idx != '0));

    // R9: done holds until start
    a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R10: busy and done are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

// File: tb/sim_ddr_powerup_seq.sv
module sim_ddr_powerup_seq;

    localparam int CLK_NS = 10;
    localparam int P_CKE  = 3;
    localparam int P_GAP  = 2;
    localparam int P_DLL  = 20;
    localparam int P_RFC  = 4;
    localparam int P_MODE = 15;
    localparam int RUN_LEN = 8 + P_CKE + 3 * P_GAP + P_DLL + 2 * P_RFC + P_MODE;

    typedef struct packed {
        logic        busy;
        logic        done;
        logic        cke;
        logic [3:0]  stb;
        logic [12:0] row;
        logic [1:0]  bank;
    } obs_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, cke, cs_n, ras_n, cas_n, we_n;
    logic [12:0] addr;
    logic [1:0]  ba;

    always #(CLK_NS / 2) clk = ~clk;

    ddr_powerup_seq #(
        .T_CKE(P_CKE), .T_GAP(P_GAP), .T_DLL(P_DLL), .T_RFC(P_RFC), .T_MODE(P_MODE)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba)
    );

    obs_t act;
    assign act = {busy, done, cke, cs_n, ras_n, cas_n, we_n, addr, ba};

    obs_t   exp_q[$];
    obs_t   exp_now = {3'b000, 4'hF, 13'h0, 2'd0};
    obs_t   last_seen;
    int     mode = 0;
    int     n_cmp = 0;
    int     n_bad = 0;
    int     cmd_seen = 0;
    int     ref_seen = 0;
    int     busy_cyc = 0;
    int     cyc = 0;
    bit     checking = 1'b0;
    string  cur_req = "R1";

    task automatic fill_queue();
        logic [3:0]  s_stb [8] = '{4'hF, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
        logic [12:0] s_row [8] = '{13'h0, 13'h400, 13'h0, 13'h132, 13'h400, 13'h0, 13'h0, 13'h032};
        logic [1:0]  s_ba  [8] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
        int          s_wt  [8] = '{P_CKE, P_GAP, P_GAP, P_DLL, P_GAP, P_RFC, P_RFC, P_MODE};
        exp_q.delete();
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back({3'b101, s_stb[i], s_row[i], s_ba[i]});
            for (int k = 0; k < s_wt[i]; k++)
                exp_q.push_back({3'b101, 4'hF, s_row[i], s_ba[i]});
        end
    endtask

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            mode = 0;
            exp_q.delete();
            exp_now = {3'b000, 4'hF, 13'h0, 2'd0};
        end else begin
            if (start && mode != 1) begin
                fill_queue();
                mode = 1;
            end
            if (mode == 1) begin
                if (exp_q.size() > 0) begin
                    exp_now = exp_q.pop_front();
                    last_seen = exp_now;
                end else begin
                    mode = 2;
                    exp_now = {3'b011, 4'hF, last_seen.row, last_seen.bank};
                end
            end
        end
    end

    task automatic check_val(string req, logic [31:0] actual, logic [31:0] expected);
        n_cmp++;
        if (actual !== expected) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (checking) begin
            n_cmp++;
            if (act !== exp_now) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", cur_req, act, exp_now);
            end
            n_cmp++;
            if (busy && done) begin
                n_bad++;
                $display("FAIL R10: actual busy=1 done=1 expected not both");
            end
            if (busy) busy_cyc++;
            if (cs_n === 1'b0) cmd_seen++;
            if ({cs_n, ras_n, cas_n, we_n} === 4'b0001) ref_seen++;
        end
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            finish_run();
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        checking = 1'b1;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check_val("R1", {cke, busy, done}, 3'b000);
        rst = 1'b0;
        cur_req = "R3";
        repeat (4) @(negedge clk);
        check_val("R3", {cs_n, ras_n, cas_n, we_n}, 4'hF);

        // First full run
        busy_cyc = 0; cmd_seen = 0; ref_seen = 0;
        cur_req = "R2";
        pulse_start();
        check_val("R2", {busy, cke, addr, ba}, {2'b11, 13'h0, 2'd0});
        cur_req = "R4/R5/R6/R7";
        wait_done();
        check_val("R4", cmd_seen, 7);
        check_val("R4", ref_seen, 2);
        check_val("R6", busy_cyc, RUN_LEN);
        check_val("R7", addr, 13'h032);

        // Done holds, then restart from done
        cur_req = "R9";
        repeat (6) @(negedge clk);
        check_val("R9", {done, busy, cke}, 3'b101);
        busy_cyc = 0; cmd_seen = 0;
        pulse_start();
        check_val("R9", {busy, done, cke}, 3'b101);

        // Start pulses during a run are ignored
        cur_req = "R8";
        repeat (5) @(negedge clk);
        pulse_start();
        repeat (9) @(negedge clk);
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        wait_done();
        check_val("R8", busy_cyc, RUN_LEN);
        check_val("R8", cmd_seen, 7);

        // Reset during a run
        pulse_start();
        cur_req = "R5";
        repeat (12) @(negedge clk);
        cur_req = "R1";
        rst = 1'b1;
        @(negedge clk);
        check_val("R1", {cke, busy, done, addr}, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        check_val("R1", {cke, cs_n, ras_n, cas_n, we_n}, 5'b01111);
        cur_req = "R3";
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule